// File: doc/BRIEF.md
# USB Device Bus Suspend Monitor

This block follows the activity seen on the data lines of a full-speed USB device and decides when the bus has gone into suspend. It runs on the 48 MHz PHY clock and counts consecutive clock cycles in which no line activity is reported. When the idle span reaches a programmable limit, the block reports suspend. It also raises a sticky early-suspend interrupt for the interrupt controller. By default the limit is 144000 cycles, which is 3 ms at 48 MHz.

Normal suspend ends when line activity returns or when software writes a remote-wakeup request. An erratic-error pulse from the protocol engine is handled differently. It sets an error flag, forces the suspended state and raises the interrupt. Neither line activity nor remote wakeup can end that state. Only a soft disconnect from software leaves it. While the soft-disconnect level is held, the block keeps itself idle, cleared and out of suspend.

Top module: `usb_suspend_monitor`

## Requirements
- R1: A synchronous active-high reset leaves the suspend output, the error flag and the interrupt all at 0, and restarts the idle count from zero.
- R2: With IDLE_LIMIT = N and no events after the count restarts, the suspend output is still 0 after N clock edges and becomes 1 at edge N+1.
- R3: The idle count saturates instead of wrapping, so a suspended bus with no events stays suspended for any length of time.
- R4: A line-activity strobe during normal suspend clears the suspend output at the next edge and restarts the idle count.
- R5: A remote-wakeup pulse during normal suspend clears the suspend output at the next edge and restarts the idle count.
- R6: An erratic-error pulse with soft disconnect low sets the error flag, the suspend output and the interrupt at the next edge.
- R7: While the error flag is 1, line activity and remote wakeup leave the suspend output and the error flag at 1.
- R8: While soft disconnect is 1, the suspend output and the error flag are 0 and error pulses are ignored. The idle count is held at zero, so suspend needs a full N+1 idle edges after release.
- R9: The interrupt becomes 1 on every entry into suspend and on every accepted error pulse. Only an interrupt-clear pulse returns it to 0, and a set in the same cycle wins over the clear.
- R10: If an error pulse and a remote-wakeup pulse arrive in the same cycle, the block ends in the error-suspended state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 48 MHz PHY clock |
| rst | input | 1 | Synchronous reset, active high |
| line_act_i | input | 1 | One-cycle strobe: activity seen on the data lines |
| rwake_req_i | input | 1 | One-cycle pulse: software requested remote wakeup |
| err_pulse_i | input | 1 | One-cycle pulse: erratic error detected |
| soft_disc_i | input | 1 | Level: software soft disconnect |
| irq_clr_i | input | 1 | One-cycle pulse: clear the early-suspend interrupt |
| susp_o | output | 1 | Bus is suspended |
| err_flag_o | output | 1 | Suspend was forced by an erratic error |
| esusp_irq_o | output | 1 | Sticky early-suspend interrupt |

## Verification
Two states are hard to reach from the ports. The first is the error-suspended state receiving the very events that end a normal suspend. The second is an entry into suspend that lands on the same edge as an interrupt clear. The vector table walks the idle count up to exactly one edge short of the limit. It then applies a clear on the entry edge, which exercises the set-over-clear ordering. Separate vectors push an error pulse, alone and together with remote wakeup, then apply activity and wakeup. They check that only a soft disconnect returns the block to normal operation.

// File: rtl/usbsusp_pkg.sv
package usbsusp_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_SUSP = 2'd1,
    ST_ERR  = 2'd2
  } susp_state_e;
endpackage

// File: rtl/usbsusp_idle_timer.sv
module usbsusp_idle_timer #(
  parameter int IDLE_LIMIT = 144000,
  localparam int CW = $clog2(IDLE_LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic restart_i,
  output logic expired_o
);
  localparam logic [CW-1:0] LIM = CW'(IDLE_LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart_i) begin
      cnt_q <= '0;
    end else if (cnt_q != LIM) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired_o = (cnt_q == LIM);
endmodule

// File: rtl/usbsusp_state_ctl.sv
module usbsusp_state_ctl
  import usbsusp_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic expired_i,
  input  logic line_act_i,
  input  logic rwake_req_i,
  input  logic err_pulse_i,
  input  logic soft_disc_i,
  output logic enter_o,
  output logic susp_o,
  output logic err_flag_o
);
  susp_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (soft_disc_i) begin
      state_d = ST_RUN;
    end else if (err_pulse_i) begin
      state_d = ST_ERR;
    end else begin
      unique case (state_q)
        ST_RUN:  if (expired_i && !line_act_i) state_d = ST_SUSP;
        ST_SUSP: if (line_act_i || rwake_req_i) state_d = ST_RUN;
        ST_ERR:  state_d = ST_ERR;
        default: state_d = ST_RUN;
      endcase
    end
  end

  assign enter_o = ((state_q == ST_RUN) && (state_d != ST_RUN)) ||
                   (err_pulse_i && !soft_disc_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_RUN;
      susp_o     <= 1'b0;
      err_flag_o <= 1'b0;
    end else begin
      state_q    <= state_d;
      susp_o     <= (state_d != ST_RUN);
      err_flag_o <= (state_d == ST_ERR);
    end
  end
endmodule

// File: rtl/usbsusp_irq_latch.sv
module usbsusp_irq_latch (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o <= 1'b0;
    end else if (set_i) begin
      irq_o <= 1'b1;
    end else if (clr_i) begin
      irq_o <= 1'b0;
    end
  end
endmodule

// File: rtl/usb_suspend_monitor.sv
module usb_suspend_monitor #(
  parameter int IDLE_LIMIT = 144000
) (
  input  logic clk,
  input  logic rst,
  input  logic line_act_i,
  input  logic rwake_req_i,
  input  logic err_pulse_i,
  input  logic soft_disc_i,
  input  logic irq_clr_i,
  output logic susp_o,
  output logic err_flag_o,
  output logic esusp_irq_o
);
  logic restart;
  logic expired;
  logic enter;

  // Any event that wakes the bus, or holds it in disconnect, restarts the idle span.
  assign restart = line_act_i | rwake_req_i | soft_disc_i;

  usbsusp_idle_timer #(.IDLE_LIMIT(IDLE_LIMIT)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .restart_i (restart),
    .expired_o (expired)
  );

  usbsusp_state_ctl u_ctl (
    .clk         (clk),
    .rst         (rst),
    .expired_i   (expired),
    .line_act_i  (line_act_i),
    .rwake_req_i (rwake_req_i),
    .err_pulse_i (err_pulse_i),
    .soft_disc_i (soft_disc_i),
    .enter_o     (enter),
    .susp_o      (susp_o),
    .err_flag_o  (err_flag_o)
  );

  usbsusp_irq_latch u_irq (
    .clk   (clk),
    .rst   (rst),
    .set_i (enter),
    .clr_i (irq_clr_i),
    .irq_o (esusp_irq_o)
  );
endmodule

// File: rtl/usb_suspend_monitor_chk.sv
module usb_suspend_monitor_chk #(
  parameter int IDLE_LIMIT = 144000,
  localparam int CW = $clog2(IDLE_LIMIT + 1)
) (
  input logic clk,
  input logic rst,
  input logic line_act_i,
  input logic rwake_req_i,
  input logic err_pulse_i,
  input logic soft_disc_i,
  input logic irq_clr_i,
  input logic susp_o,
  input logic err_flag_o,
  input logic esusp_irq_o
);
  localparam logic [CW-1:0] LIM = CW'(IDLE_LIMIT);
  logic [CW-1:0] idle_seen;

  always_ff @(posedge clk) begin
    if (rst || line_act_i || rwake_req_i || soft_disc_i) idle_seen <= '0;
    else if (idle_seen != LIM) idle_seen <= idle_seen + 1'b1;
  end

  p_early_entry_r2: assert property (@(posedge clk) disable iff (rst)
    (!susp_o && idle_seen < LIM && !err_pulse_i) |=> !susp_o);

  p_err_implies_susp_r6: assert property (@(posedge clk) disable iff (rst)
    err_flag_o |-> susp_o);

  p_err_sets_r6: assert property (@(posedge clk) disable iff (rst)
    (err_pulse_i && !soft_disc_i) |=> (err_flag_o && esusp_irq_o));

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (err_flag_o && !soft_disc_i) |=> err_flag_o);

  p_act_wakes_r4: assert property (@(posedge clk) disable iff (rst)
    (susp_o && !err_flag_o && line_act_i && !err_pulse_i && !soft_disc_i) |=> !susp_o);

  p_rwake_wakes_r5: assert property (@(posedge clk) disable iff (rst)
    (susp_o && !err_flag_o && rwake_req_i && !err_pulse_i && !soft_disc_i) |=> !susp_o);

  p_disc_clears_r8: assert property (@(posedge clk) disable iff (rst)
    soft_disc_i |=> (!susp_o && !err_flag_o));

  p_irq_on_entry_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(susp_o) |-> esusp_irq_o);

  p_irq_clear_only_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(esusp_irq_o) |-> $past(irq_clr_i));
endmodule

bind usb_suspend_monitor usb_suspend_monitor_chk #(.IDLE_LIMIT(IDLE_LIMIT)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .line_act_i  (line_act_i),
  .rwake_req_i (rwake_req_i),
  .err_pulse_i (err_pulse_i),
  .soft_disc_i (soft_disc_i),
  .irq_clr_i   (irq_clr_i),
  .susp_o      (susp_o),
  .err_flag_o  (err_flag_o),
  .esusp_irq_o (esusp_irq_o)
);

// File: tb/sim_usb_suspend_monitor.sv
module sim_usb_suspend_monitor;
  localparam int LIMIT = 20;
  localparam int NV = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line_act = 1'b0, rwake = 1'b0, err_p = 1'b0, disc = 1'b0, clr = 1'b0;
  logic susp, errf, irq;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  usb_suspend_monitor #(.IDLE_LIMIT(LIMIT)) u0 (
    .clk(clk), .rst(rst), .line_act_i(line_act), .rwake_req_i(rwake),
    .err_pulse_i(err_p), .soft_disc_i(disc), .irq_clr_i(clr),
    .susp_o(susp), .err_flag_o(errf), .esusp_irq_o(irq)
  );

  // {act, rwake, err, disc, clr} [19:15], idle edges [14:7], {susp, err, irq} [6:4], req [3:0]
  localparam logic [19:0] VEC [NV] = '{
    20'b10000_00000101_000_0100, // R4 activity restarts count
    20'b00000_00001101_000_0010, // R2 count reaches N-1
    20'b00000_00000000_000_0010, // R2 count at N, still awake
    20'b00000_00000000_101_0010, // R2 entry on edge N+1
    20'b00001_00000000_100_1001, // R9 clear
    20'b10000_00000000_000_0100, // R4 wake on activity
    20'b00000_00010100_101_0010, // R2 re-entry
    20'b01000_00000000_001_0101, // R5 wake on remote wakeup
    20'b00001_00000011_000_1001, // R9 clear
    20'b00100_00000000_111_0110, // R6 error forces suspend
    20'b10000_00000010_111_0111, // R7 activity ignored
    20'b01000_00000000_111_0111, // R7 wakeup ignored
    20'b00001_00000000_110_1001, // R9 clear while error held
    20'b00010_00000000_000_1000, // R8 soft disconnect exits
    20'b01100_00000000_111_1010, // R10 error beats wakeup
    20'b00010_00000000_001_1000, // R8 disconnect, irq kept
    20'b00001_00010011_000_1001, // R9 clear, count to N
    20'b00001_00000000_101_1001, // R9 entry beats clear
    20'b00000_11001000_101_0011, // R3 long idle stays suspended
    20'b10000_00000000_001_0100  // R4 wake after saturation
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect3(input string req, input logic [2:0] exp);
    checks++;
    if ({susp, errf, irq} !== exp) begin
      fails++;
      $display("FAIL %s: {susp,err,irq} actual=%b expected=%b", req, {susp, errf, irq}, exp);
    end
  endtask

  task automatic run_all();
    @(negedge clk);
    tick();
    rst = 1'b0;
    expect3("R1", 3'b000); // reset state
    for (int v = 0; v < NV; v++) begin
      {line_act, rwake, err_p, disc, clr} = VEC[v][19:15];
      tick();
      {line_act, rwake, err_p, disc, clr} = '0;
      for (int w = 0; w < int'(VEC[v][14:7]); w++) tick();
      expect3($sformatf("R%0d vec%0d", VEC[v][3:0], v), VEC[v][6:4]);
    end
    // R8: held disconnect, error pulse ignored, count held at zero
    disc = 1'b1;
    for (int k = 0; k < 30; k++) begin
      err_p = (k == 10);
      tick();
    end
    err_p = 1'b0;
    expect3("R8 hold", 3'b001);
    disc = 1'b0;
    for (int k = 0; k < LIMIT; k++) tick();
    expect3("R8 release N edges", 3'b001);
    tick();
    expect3("R8 release N+1 edges", 3'b101);
    // R1: reset while suspended
    rst = 1'b1;
    tick();
    rst = 1'b0;
    expect3("R1 mid-run", 3'b000);
  endtask

  initial begin
    fork
      run_all();
      begin
        #(8 * 5000);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule